// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block owns a small word-addressed shared memory and serves a fixed number of cores through one request port each. Every core can issue a plain load or store, or one of four indivisible read-modify-write operations: swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. Each of these runs as a single operation that no other access can split.

Requests that arrive together are put in order by a round-robin arbiter. The arbiter grants exactly one core per cycle. The granted operation reads and updates memory on that same clock edge, so an atomic operation finishes before the next access starts. One cycle after the grant the block returns the old memory word, or for a store-conditional a success flag, tagged with the index of the core that issued it.

Each core keeps one reservation, made of a valid bit and an address. A load-linked sets it. A write to that address by any core clears it. The core's own store-conditional also clears it, whether it succeeds or fails.

Top module: `amo_unit`

## Requirements
- R1: After reset every memory word reads 0, no response is valid, and no core holds a reservation, so a store-conditional issued before any load-linked returns 0.
- R2: At most one core is granted per cycle, and only a core that is requesting. When any core requests, one core is granted. The search for a grant starts at the core after the one granted last and wraps around; after reset core 0 comes first.
- R3: Every grant produces exactly one response with `rsp_valid` high in the following cycle. `rsp_core` carries the index of the granted core. There is no response in a cycle after a cycle with no grant.
- R4: A load (opcode 0) returns the word at the address. A store (opcode 1) writes the write data and returns the word it replaced.
- R5: A swap (opcode 2) writes the write data and returns the previous word, as one operation.
- R6: A test-and-set (opcode 3) returns the previous word. It writes the write data only when that previous word is zero; otherwise memory is left as it was.
- R7: A fetch-and-increment (opcode 4) returns the previous word and stores that word plus one, wrapping to 0 at the all-ones value.
- R8: A load-linked (opcode 5) returns the word and records a reservation for that core and address. A store-conditional (opcode 6) from the same core to the same address, with the reservation still valid, writes the write data and returns 1.
- R9: A store-conditional without a matching valid reservation returns 0 and leaves memory unchanged. Every store-conditional clears the issuing core's reservation, so a second one in a row fails.
- R10: Any write by any core to a reserved address clears every reservation on that address. This covers stores, swaps, increments, a test-and-set that writes, and a store-conditional that succeeds. Writes to other addresses and a test-and-set that does not write leave the reservation in place.
- R11: A swap of 1 into a lock word returns 0 when the lock was free and nonzero when it was held. After the holder stores 0, a waiting core's swap returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core request valid; the core holds it until granted |
| req_op | input | NUM_CORES*3 | Per-core opcode, core i in bits [3i+2:3i] |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address |
| req_wdata | input | NUM_CORES*DATA_W | Per-core write data |
| req_ready | output | NUM_CORES | One-hot grant; the request is executed on this edge |
| rsp_valid | output | 1 | Response valid, one cycle after a grant |
| rsp_core | output | IDX_W | Index of the core the response belongs to |
| rsp_data | output | DATA_W | Old word, or 0/1 success for a store-conditional |

## Verification
The assertions assume that a core keeps its request fields stable while `req_valid` is high and not yet granted. They also assume that opcodes 7 and above are never sent. The bench meets both assumptions: each request is driven at a falling edge, held until the core sees its own `req_ready`, and dropped just after the granting rising edge. Only the seven defined opcodes are used. The contention cases raise several `req_valid` bits at the same falling edge, which exercises the arbiter's rotation without breaking the hold-until-granted assumption.

// File: rtl/amo_pkg.sv
// Shared definitions for the atomic memory unit: opcode encoding and width.
// Assumes opcode values above AMO_SC are never issued.
package amo_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        AMO_LOAD  = 3'd0,
        AMO_STORE = 3'd1,
        AMO_SWAP  = 3'd2,
        AMO_TAS   = 3'd3,
        AMO_FINC  = 3'd4,
        AMO_LL    = 3'd5,
        AMO_SC    = 3'd6
    } amo_op_e;
endpackage

// File: rtl/amo_rr_arbiter.sv
// Round-robin arbiter: grants one requester per cycle, searching from the
// requester after the last one granted. Assumes requests are held until granted.
module amo_rr_arbiter #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             grant_any
);
    logic [IDX_W-1:0] last_q;

    // Pick the first active requester after last_q, wrapping around.
    always_comb begin
        int cand;
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        cand      = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last_q) + k) % N;
            if (!grant_any && req[cand]) begin
                grant_any   = 1'b1;
                grant[cand] = 1'b1;
                grant_idx   = IDX_W'(cand);
            end
        end
    end

    // Remember the most recent grant; reset makes core 0 first in line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDX_W'(N - 1);
        else if (grant_any)
            last_q <= grant_idx;
    end
endmodule

// File: rtl/amo_resv_table.sv
// Per-core reservation table for load-linked / store-conditional.
// Each core has one valid bit and one address. Assumes at most one
// operation executes per cycle (exec).
module amo_resv_table #(
    parameter int N      = 4,
    parameter int ADDR_W = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [IDX_W-1:0]  core,
    input  logic [ADDR_W-1:0] addr,
    input  logic              set_en,
    input  logic              sc_op,
    input  logic              wr_en,
    output logic              hit
);
    logic [N-1:0]      rv_q;
    logic [ADDR_W-1:0] ra_q [N];
    logic [N-1:0]      match;

    for (genvar i = 0; i < N; i++) begin : g_slot
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);

        // Set on this core's load-linked; clear on its own SC or any write to the address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rv_q[i] <= 1'b0;
                ra_q[i] <= '0;
            end else if (exec && set_en && core == ME) begin
                rv_q[i] <= 1'b1;
                ra_q[i] <= addr;
            end else if (exec && ((sc_op && core == ME) || (wr_en && ra_q[i] == addr))) begin
                rv_q[i] <= 1'b0;
            end
        end

        // Per-core address match of a valid reservation.
        assign match[i] = rv_q[i] && (ra_q[i] == addr);
    end

    assign hit = match[core];
endmodule

// File: rtl/amo_alu.sv
// Read-modify-write datapath: from the opcode, the old word, the write data
// and the reservation match, it decides whether memory is written, the new
// word, and the response value. Purely combinational.
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  amo_op_e           op,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  logic              resv_hit,
    output logic              wr_en,
    output logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] rsp_val
);
    // Opcode decode into write enable, written word and returned word.
    always_comb begin
        wr_en   = 1'b0;
        new_val = wdata;
        rsp_val = old_val;
        unique case (op)
            AMO_STORE, AMO_SWAP: wr_en = 1'b1;
            AMO_TAS:             wr_en = (old_val == '0);
            AMO_FINC: begin
                wr_en   = 1'b1;
                new_val = old_val + DATA_W'(1);
            end
            AMO_SC: begin
                wr_en   = resv_hit;
                rsp_val = {{(DATA_W-1){1'b0}}, resv_hit};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amo_mem.sv
// Word storage with an asynchronous read port and a synchronous write port.
// Cleared to zero on reset. Assumes a small depth (register-based).
module amo_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    // Clear on reset, otherwise write the selected word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];
endmodule

// File: rtl/amo_unit.sv
// Atomic memory operation unit: arbitrates the per-core request ports, runs
// the granted operation in one cycle against the shared memory and the
// reservation table, and registers a response one cycle after the grant.
// Assumes each core holds its request fields until it sees req_ready.
module amo_unit
    import amo_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        req_valid,
    input  logic [NUM_CORES*OP_W-1:0]   req_op,
    input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
    input  logic [NUM_CORES*DATA_W-1:0] req_wdata,
    output logic [NUM_CORES-1:0]        req_ready,
    output logic                        rsp_valid,
    output logic [IDX_W-1:0]            rsp_core,
    output logic [DATA_W-1:0]           rsp_data
);
    logic [IDX_W-1:0]  gnt_idx;
    logic              gnt_any;
    amo_op_e           sel_op;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] new_val;
    logic [DATA_W-1:0] rsp_val;
    logic              alu_wr;
    logic              mem_wr;
    logic              resv_hit;

    amo_rr_arbiter #(.N(NUM_CORES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .grant     (req_ready),
        .grant_idx (gnt_idx),
        .grant_any (gnt_any)
    );

    // Select the granted core's request fields.
    always_comb begin
        sel_op    = amo_op_e'(req_op[gnt_idx*OP_W +: OP_W]);
        sel_addr  = req_addr[gnt_idx*ADDR_W +: ADDR_W];
        sel_wdata = req_wdata[gnt_idx*DATA_W +: DATA_W];
    end

    amo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mem_wr),
        .addr  (sel_addr),
        .wdata (new_val),
        .rdata (old_val)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (sel_op),
        .old_val  (old_val),
        .wdata    (sel_wdata),
        .resv_hit (resv_hit),
        .wr_en    (alu_wr),
        .new_val  (new_val),
        .rsp_val  (rsp_val)
    );

    assign mem_wr = gnt_any && alu_wr;

    amo_resv_table #(.N(NUM_CORES), .ADDR_W(ADDR_W)) u_resv (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec   (gnt_any),
        .core   (gnt_idx),
        .addr   (sel_addr),
        .set_en (sel_op == AMO_LL),
        .sc_op  (sel_op == AMO_SC),
        .wr_en  (alu_wr),
        .hit    (resv_hit)
    );

    // Register the response of the executed operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_core  <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= gnt_any;
            if (gnt_any) begin
                rsp_core <= gnt_idx;
                rsp_data <= rsp_val;
            end
        end
    end
endmodule

// File: rtl/amo_unit_chk.sv
// Checker for amo_unit: grant and response protocol properties.
// Assumes requests are held stable until granted.
module amo_unit_chk
    import amo_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CORES-1:0]      req_valid,
    input logic [NUM_CORES*OP_W-1:0] req_op,
    input logic [NUM_CORES-1:0]      req_ready,
    input logic                      rsp_valid,
    input logic [IDX_W-1:0]          rsp_core,
    input logic [DATA_W-1:0]         rsp_data
);
    logic [IDX_W-1:0] g_idx;
    logic [OP_W-1:0]  g_op;

    // Encode the one-hot grant independently of the arbiter's index.
    always_comb begin
        g_idx = '0;
        for (int i = 0; i < NUM_CORES; i++)
            if (req_ready[i]) g_idx = IDX_W'(i);
        g_op = req_op[g_idx*OP_W +: OP_W];
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rsp_valid);

    assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    assert_grant_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    assert_work_conserving_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_valid) |-> (|req_ready));

    assert_rsp_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> rsp_valid);

    assert_no_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_ready) |=> !rsp_valid);

    assert_rsp_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_ready) |=> (rsp_core == $past(g_idx)));

    assert_sc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_ready) && g_op == OP_W'(AMO_SC)) |=> (rsp_data < DATA_W'(2)));
endmodule

bind amo_unit amo_unit_chk #(
    .NUM_CORES (NUM_CORES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_core  (rsp_core),
    .rsp_data  (rsp_data)
);

// File: tb/tb_amo_unit.sv
// Scoreboard bench: drivers compute expected responses from a model of the
// requirements at grant time; a monitor compares responses as they appear.
module tb_amo_unit;
    import amo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0]      req_valid = '0;
    logic [NC*OP_W-1:0] req_op    = '0;
    logic [NC*AW-1:0]   req_addr  = '0;
    logic [NC*DW-1:0]   req_wdata = '0;
    logic [NC-1:0]      req_ready;
    logic               rsp_valid;
    logic [1:0]         rsp_core;
    logic [DW-1:0]      rsp_data;

    int checks = 0;
    int failures = 0;
    int            q_core [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];
    int            grant_log [$];

    logic [DW-1:0] m_mem [16];
    logic          m_rv  [NC];
    logic [AW-1:0] m_ra  [NC];

    amo_unit #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_core  (rsp_core),
        .rsp_data  (rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model of the requirements: returns the expected response, updates state.
    function automatic logic [DW-1:0] model_exec(int c, amo_op_e op, logic [AW-1:0] a,
                                                 logic [DW-1:0] wd);
        logic [DW-1:0] old = m_mem[a];
        logic [DW-1:0] nv  = wd;
        logic [DW-1:0] r   = old;
        logic          wr  = 1'b0;
        case (op)
            AMO_STORE, AMO_SWAP: wr = 1'b1;
            AMO_TAS:  wr = (old == '0);
            AMO_FINC: begin wr = 1'b1; nv = old + 1; end
            AMO_LL:   begin m_rv[c] = 1'b1; m_ra[c] = a; end
            AMO_SC: begin
                wr = m_rv[c] && (m_ra[c] == a);
                r  = {{(DW-1){1'b0}}, wr};
                m_rv[c] = 1'b0;
            end
            default: ;
        endcase
        if (wr) begin
            m_mem[a] = nv;
            for (int k = 0; k < NC; k++)
                if (m_ra[k] == a) m_rv[k] = 1'b0;
        end
        return r;
    endfunction

    // Driver: raise a request, wait for its grant, push the expected response.
    task automatic issue(input int c, input amo_op_e op, input int a,
                         input logic [DW-1:0] wd, input string tag);
        @(negedge clk);
        req_op[c*OP_W +: OP_W] = op;
        req_addr[c*AW +: AW]   = AW'(a);
        req_wdata[c*DW +: DW]  = wd;
        req_valid[c]           = 1'b1;
        #1;
        while (!req_ready[c]) begin
            @(negedge clk);
            #1;
        end
        q_core.push_back(c);
        q_data.push_back(model_exec(c, op, AW'(a), wd));
        q_tag.push_back(tag);
        grant_log.push_back(c);
        @(posedge clk);
        #1;
        req_valid[c] = 1'b0;
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (q_core.size() == 0) begin
                failures++;
                $display("FAIL R3 unexpected response: got core=%0d data=%0h expected none",
                         rsp_core, rsp_data);
            end else begin
                int            ec;
                logic [DW-1:0] ed;
                string         et;
                ec = q_core.pop_front();
                ed = q_data.pop_front();
                et = q_tag.pop_front();
                if (int'(rsp_core) != ec || rsp_data !== ed) begin
                    failures++;
                    $display("FAIL %s: got core=%0d data=%0h expected core=%0d data=%0h",
                             et, rsp_core, rsp_data, ec, ed);
                end
            end
        end
    end

    task automatic check_log(input int exp_order [$], input string tag);
        checks++;
        if (grant_log != exp_order) begin
            failures++;
            $display("FAIL %s: got grant order %p expected %p", tag, grant_log, exp_order);
        end
        grant_log.delete();
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3: got no completion expected completion within limit");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
        for (int i = 0; i < NC; i++) begin m_rv[i] = 1'b0; m_ra[i] = '0; end

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== '0) begin
            failures++;
            $display("FAIL R1 reset state: got rsp_valid=%b ready=%b expected 0 0",
                     rsp_valid, req_ready);
        end
        grant_log.delete();

        // R2 R7: four cores increment one word at once; order 0,1,2,3 after reset.
        fork
            issue(0, AMO_FINC, 5, '0, "R7 contended increment core0");
            issue(1, AMO_FINC, 5, '0, "R7 contended increment core1");
            issue(2, AMO_FINC, 5, '0, "R7 contended increment core2");
            issue(3, AMO_FINC, 5, '0, "R7 contended increment core3");
        join
        check_log('{0, 1, 2, 3}, "R2 grant order after reset");

        // R4: load and store.
        issue(0, AMO_LOAD,  5, '0,       "R4 load after four increments");
        issue(1, AMO_STORE, 6, 32'hA5,   "R4 store returns replaced word");
        issue(2, AMO_LOAD,  6, '0,       "R4 load sees stored word");
        issue(3, AMO_LOAD,  3, '0,       "R1 untouched word reads zero");

        // R5 R11: spin lock through swaps.
        issue(1, AMO_SWAP,  7, 32'd1,    "R11 acquire free lock");
        issue(2, AMO_SWAP,  7, 32'd1,    "R11 swap on held lock");
        issue(1, AMO_STORE, 7, 32'd0,    "R11 release lock");
        issue(2, AMO_SWAP,  7, 32'd1,    "R11 waiter acquires");
        issue(0, AMO_SWAP,  7, 32'h1234, "R5 swap returns previous word");

        // R6: test-and-set writes only on zero.
        issue(0, AMO_TAS,  8, 32'h55, "R6 tas on zero");
        issue(0, AMO_TAS,  8, 32'h77, "R6 tas on nonzero");
        issue(3, AMO_LOAD, 8, '0,     "R6 nonzero tas left memory unchanged");

        // R7: wrap at all ones.
        issue(1, AMO_STORE, 9, 32'hFFFF_FFFF, "R7 preload all ones");
        issue(1, AMO_FINC,  9, '0,            "R7 increment all ones");
        issue(1, AMO_LOAD,  9, '0,            "R7 wrapped to zero");

        // R1 R9: store-conditional without reservation fails.
        issue(3, AMO_SC,   10, 32'd9, "R1 sc with no reservation after reset");
        issue(3, AMO_LOAD, 10, '0,    "R9 failed sc left memory unchanged");

        // R8 R9: success, then own reservation gone.
        issue(0, AMO_LL,   10, '0,     "R8 load-linked value");
        issue(0, AMO_SC,   10, 32'h11, "R8 sc succeeds");
        issue(0, AMO_SC,   10, 32'h22, "R9 second sc fails");
        issue(2, AMO_LOAD, 10, '0,     "R8 R9 memory holds first sc data");

        // R10: another core's store to the linked address breaks it.
        issue(0, AMO_LL,    11, '0,    "R10 link word 11");
        issue(1, AMO_STORE, 11, 32'd3, "R10 intervening store");
        issue(0, AMO_SC,    11, 32'd4, "R10 sc fails after store");
        issue(0, AMO_LOAD,  11, '0,    "R10 memory holds intervening store");

        // R10: a store elsewhere keeps the reservation.
        issue(0, AMO_LL,    12, '0,    "R10 link word 12");
        issue(1, AMO_STORE, 13, 32'd8, "R10 store to other word");
        issue(0, AMO_SC,    12, 32'd6, "R10 sc succeeds across unrelated store");

        // R10: a non-writing test-and-set keeps the reservation.
        issue(3, AMO_STORE, 14, 32'd5, "R10 preload word 14");
        issue(2, AMO_LL,    14, '0,    "R10 link word 14");
        issue(1, AMO_TAS,   14, 32'd9, "R10 tas without write");
        issue(2, AMO_SC,    14, 32'd6, "R10 sc succeeds after idle tas");

        // R10: two links on one word; the first sc to land wins.
        issue(0, AMO_LL, 15, '0,    "R10 core0 links word 15");
        issue(1, AMO_LL, 15, '0,    "R10 core1 links word 15");
        issue(0, AMO_SC, 15, 32'd1, "R10 core0 sc wins");
        issue(1, AMO_SC, 15, 32'd2, "R10 core1 sc loses");

        // R10: increment and swap also clear a reservation.
        issue(2, AMO_LL,   4, '0,    "R10 link word 4");
        issue(3, AMO_FINC, 4, '0,    "R10 increment linked word");
        issue(2, AMO_SC,   4, 32'd7, "R10 sc fails after increment");
        issue(2, AMO_LL,   4, '0,    "R10 relink word 4");
        issue(0, AMO_SWAP, 4, 32'd2, "R10 swap linked word");
        issue(2, AMO_SC,   4, 32'd7, "R10 sc fails after swap");

        // R2: rotation, core 2 granted last so core 3 beats core 1.
        issue(2, AMO_LOAD, 0, '0, "R2 single grant core2");
        grant_log.delete();
        fork
            issue(1, AMO_LOAD, 1, '0, "R2 rotated pair core1");
            issue(3, AMO_LOAD, 2, '0, "R2 rotated pair core3");
        join
        check_log('{3, 1}, "R2 rotation after core2");

        repeat (3) @(negedge clk);
        checks++;
        if (q_core.size() != 0) begin
            failures++;
            $display("FAIL R3 missing responses: got %0d pending expected 0", q_core.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule